// File: doc/BRIEF.md
# Switch Request Forwarding Permission Checker

This block sits in the request path of a packet switch that has one upstream port (port 0) and several downstream ports in a partition. For each memory, I/O or VGA request, an earlier stage has already decoded the address windows. The checker receives that decoded descriptor and decides one of three outcomes: forward the request to a port, send it upstream, or reject it as an unsupported request. The descriptor carries the ingress port, the request kind, a match bit per port, and per-port enable bits.

A rejected request carries exactly one error class. Classes are chosen by fixed priority: an ingress access-enable failure first, then a bus-master failure, then a routing failure. The verdict is registered one cycle after acceptance. Both sides use a valid/ready handshake, and a stalled verdict is held unchanged. The egress is one-hot, so the datapath can use it directly as a port select.

Top module: `sw_fwd_permit`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: A request is accepted on a clock edge where in_valid and in_ready are both 1, and its verdict shows on out_valid the next cycle. in_ready equals (not out_valid) or out_ready. A verdict with out_ready low is held unchanged.
- R3: Memory (kind 0) and VGA (kind 2) requests need the ingress port's mem_en bit. I/O (kind 1) requests need its io_en bit. If the bit is clear, the code is 1 (enable fault).
- R4: A memory, VGA or I/O request entering a downstream port whose bm_en bit is clear gets code 2 (master fault).
- R5: A permitted request whose resolved target is the upstream port gets code 2 when bm_en[0] is clear.
- R6: A request entering the upstream port goes to the lowest-numbered matching downstream port. If no downstream port matches, it gets code 3 (route fault), whether or not the upstream bit matches.
- R7: A request entering a downstream port is resolved in this order: first the lowest-numbered other matching downstream port; else its own port (loopback); else the upstream port if in_match[0] is set. If none applies, it gets code 3.
- R8: A loopback goes to the upstream port when upfwd_en of the ingress port is 1. When that bit is 0, the loopback gets code 3.
- R9: A VGA request entering a downstream port whose vga_en bit is set gets code 3.
- R10: When several faults apply, the code is the first in the order enable (1), master (2), route (3).
- R11: A verdict with code 0 has exactly one bit set in out_egress, where bit i means port i. Any nonzero code has out_egress all zero.
- R12: Kind 3 is reserved and always gets code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request descriptor valid |
| in_ready | output | 1 | Checker can take a descriptor |
| in_port | input | PORT_W | Ingress port index, 0 = upstream |
| in_kind | input | 2 | 0 memory, 1 I/O, 2 VGA, 3 reserved |
| in_match | input | NUM_PORTS | Address window hit per port |
| mem_en | input | NUM_PORTS | Memory access enable per port |
| io_en | input | NUM_PORTS | I/O access enable per port |
| bm_en | input | NUM_PORTS | Bus master enable per port |
| vga_en | input | NUM_PORTS | VGA enable per port |
| upfwd_en | input | NUM_PORTS | Upstream forwarding of loopbacks per port |
| out_valid | output | 1 | Verdict valid |
| out_ready | input | 1 | Consumer takes the verdict |
| out_egress | output | NUM_PORTS | One-hot egress port, zero on fault |
| out_code | output | 2 | 0 ok, 1 enable, 2 master, 3 route |

## Verification
On every cycle, the assertions check the handshake timing and that a stalled verdict is held. They also check that the egress is one-hot and agrees with the code. They additionally check two priority cases: a disabled I/O request always yields an enable fault, and a downstream bus-master failure outranks routing. Target selection among several matching windows, loopback handling with and without upstream forwarding, the upstream bus-master rule, the VGA-source restriction and the reserved kind are shown only by the bench. It drives directed corners and seeded random descriptors and compares each verdict with its own model.

// File: rtl/sw_fwd_pkg.sv
// Shared encodings for the forwarding permission checker.
// Assumes port 0 is the upstream port of the partition.
package sw_fwd_pkg;
    typedef enum logic [1:0] {
        KIND_MEM = 2'd0,
        KIND_IO  = 2'd1,
        KIND_VGA = 2'd2,
        KIND_RSV = 2'd3
    } req_kind_t;

    typedef enum logic [1:0] {
        CODE_OK     = 2'd0,
        CODE_ENABLE = 2'd1,
        CODE_MASTER = 2'd2,
        CODE_ROUTE  = 2'd3
    } fault_code_t;
endpackage

// File: rtl/sw_fwd_route.sv
// Target resolution from address match bits.
// Upstream ingress: lowest matching downstream port, else no target.
// Downstream ingress: lowest other matching downstream port, then own port
// (loopback, reported on tgt bit 0), then the upstream port.
// Assumes in_port < NUM_PORTS.
module sw_fwd_route #(
    parameter int NUM_PORTS = 5,
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [PORT_W-1:0]    in_port,
    input  logic [NUM_PORTS-1:0] in_match,
    output logic [NUM_PORTS-1:0] tgt,
    output logic                 tgt_hit,
    output logic                 is_loop
);
    logic [NUM_PORTS-1:0] self_bit;
    logic [NUM_PORTS-1:0] ds_mask;
    logic [NUM_PORTS-1:0] other;
    logic [NUM_PORTS-1:0] pick;

    // Build a per-port mask of downstream candidates (all except port 0).
    genvar g;
    generate
        for (g = 0; g < NUM_PORTS; g++) begin : g_mask
            assign ds_mask[g]  = (g != 0);
            assign self_bit[g] = (in_port == PORT_W'(g));
        end
    endgenerate

    assign other = in_match & ds_mask & ~self_bit;
    assign pick  = other & (~other + NUM_PORTS'(1));

    // Choose the target by the fixed preference order.
    always_comb begin
        tgt     = '0;
        tgt_hit = 1'b0;
        is_loop = 1'b0;
        if (other != '0) begin
            tgt     = pick;
            tgt_hit = 1'b1;
        end else if (in_port != '0) begin
            if ((in_match & self_bit) != '0) begin
                tgt     = NUM_PORTS'(1);
                tgt_hit = 1'b1;
                is_loop = 1'b1;
            end else if (in_match[0]) begin
                tgt     = NUM_PORTS'(1);
                tgt_hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sw_fwd_judge.sv
// Permission checks and fault priority: enable, then master, then route.
// Assumes tgt is one-hot when tgt_hit is set; egress is zero on any fault.
module sw_fwd_judge
    import sw_fwd_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [PORT_W-1:0]    in_port,
    input  logic [1:0]           in_kind,
    input  logic [NUM_PORTS-1:0] mem_en,
    input  logic [NUM_PORTS-1:0] io_en,
    input  logic [NUM_PORTS-1:0] bm_en,
    input  logic [NUM_PORTS-1:0] vga_en,
    input  logic [NUM_PORTS-1:0] upfwd_en,
    input  logic [NUM_PORTS-1:0] tgt,
    input  logic                 tgt_hit,
    input  logic                 is_loop,
    output logic [1:0]           code,
    output logic [NUM_PORTS-1:0] egress
);
    req_kind_t kind;
    logic      from_ds;
    logic      loop_blocked;
    logic      goes_up;
    logic      en_fail;
    logic      bm_fail;
    logic      rt_fail;

    assign kind    = req_kind_t'(in_kind);
    assign from_ds = (in_port != '0);

    // Classify each fault separately.
    always_comb begin
        loop_blocked = is_loop && !upfwd_en[in_port];
        goes_up      = tgt_hit && tgt[0] && !loop_blocked;
        unique case (kind)
            KIND_IO:  en_fail = !io_en[in_port];
            KIND_RSV: en_fail = 1'b0;
            default:  en_fail = !mem_en[in_port];
        endcase
        bm_fail = (kind != KIND_RSV) &&
                  ((from_ds && !bm_en[in_port]) || (goes_up && !bm_en[0]));
        rt_fail = (kind == KIND_RSV) || !tgt_hit || loop_blocked ||
                  ((kind == KIND_VGA) && from_ds && vga_en[in_port]);
    end

    // Reduce the faults to one code by priority.
    always_comb begin
        if (en_fail)      code = CODE_ENABLE;
        else if (bm_fail) code = CODE_MASTER;
        else if (rt_fail) code = CODE_ROUTE;
        else              code = CODE_OK;
        egress = (code == CODE_OK) ? tgt : '0;
    end
endmodule

// File: rtl/sw_fwd_permit.sv
// Top: one-stage registered verdict with valid/ready on both sides.
// Assumes in_port < NUM_PORTS and port 0 is upstream.
module sw_fwd_permit
    import sw_fwd_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [PORT_W-1:0]    in_port,
    input  logic [1:0]           in_kind,
    input  logic [NUM_PORTS-1:0] in_match,
    input  logic [NUM_PORTS-1:0] mem_en,
    input  logic [NUM_PORTS-1:0] io_en,
    input  logic [NUM_PORTS-1:0] bm_en,
    input  logic [NUM_PORTS-1:0] vga_en,
    input  logic [NUM_PORTS-1:0] upfwd_en,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [NUM_PORTS-1:0] out_egress,
    output logic [1:0]           out_code
);
    logic [NUM_PORTS-1:0] tgt;
    logic                 tgt_hit;
    logic                 is_loop;
    logic [1:0]           nxt_code;
    logic [NUM_PORTS-1:0] nxt_egress;
    logic                 take;

    sw_fwd_route #(.NUM_PORTS(NUM_PORTS)) route_i (
        .in_port (in_port),
        .in_match(in_match),
        .tgt     (tgt),
        .tgt_hit (tgt_hit),
        .is_loop (is_loop)
    );

    sw_fwd_judge #(.NUM_PORTS(NUM_PORTS)) judge_i (
        .in_port (in_port),
        .in_kind (in_kind),
        .mem_en  (mem_en),
        .io_en   (io_en),
        .bm_en   (bm_en),
        .vga_en  (vga_en),
        .upfwd_en(upfwd_en),
        .tgt     (tgt),
        .tgt_hit (tgt_hit),
        .is_loop (is_loop),
        .code    (nxt_code),
        .egress  (nxt_egress)
    );

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    // Output register: load on accept, drop valid once consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_egress <= '0;
            out_code   <= CODE_OK;
        end else if (take) begin
            out_valid  <= 1'b1;
            out_egress <= nxt_egress;
            out_code   <= nxt_code;
        end else if (out_ready) begin
            out_valid  <= 1'b0;
        end
    end

    AST_EGRESS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0(out_egress)); // R11
    AST_CODE_EGRESS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_code == CODE_OK) == (out_egress != '0))); // R11
    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_egress) && $stable(out_code))); // R2
    AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> out_valid); // R2
    AST_IO_ENABLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_kind == KIND_IO && !io_en[in_port]) |=> (out_code == CODE_ENABLE)); // R10
    AST_DS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_port != '0 && in_kind == KIND_MEM && mem_en[in_port] && !bm_en[in_port])
        |=> (out_code == CODE_MASTER)); // R4
endmodule

// File: tb/sw_fwd_permit_tb_top.sv
// Bench: directed corners plus seeded random descriptors, compared with a model.
module sw_fwd_permit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 5;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [PW-1:0] in_port = '0;
    logic [1:0]    in_kind = '0;
    logic [NP-1:0] in_match = '0, mem_en = '0, io_en = '0, bm_en = '0, vga_en = '0, upfwd_en = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [NP-1:0] out_egress;
    logic [1:0]    out_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sw_fwd_permit #(.NUM_PORTS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_port(in_port), .in_kind(in_kind), .in_match(in_match),
        .mem_en(mem_en), .io_en(io_en), .bm_en(bm_en), .vga_en(vga_en),
        .upfwd_en(upfwd_en), .out_valid(out_valid), .out_ready(out_ready),
        .out_egress(out_egress), .out_code(out_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model of the requirements: returns {egress, code}.
    function automatic logic [NP+1:0] model(input int p, input int k, input logic [NP-1:0] m);
        int  t = -1;
        bit  loop = 0;
        logic [1:0] c;
        for (int i = 1; i < NP; i++)
            if (t < 0 && i != p && m[i]) t = i;
        if (t < 0 && p != 0) begin
            if (m[p]) begin t = 0; loop = 1; end
            else if (m[0]) t = 0;
        end
        if (k == 1 ? !io_en[p] : (k != 3 && !mem_en[p])) c = 2'd1;                       // R3
        else if (k != 3 && ((p != 0 && !bm_en[p]) ||
                 (t == 0 && !(loop && !upfwd_en[p]) && !bm_en[0]))) c = 2'd2;           // R4 R5
        else if (k == 3 || t < 0 || (loop && !upfwd_en[p]) ||
                 (k == 2 && p != 0 && vga_en[p])) c = 2'd3;                              // R6 R7 R8 R9 R12
        else c = 2'd0;
        return {(c == 2'd0) ? (NP'(1) << t) : NP'(0), c};
    endfunction

    task automatic run_one(input string req, input int p, input int k,
                           input logic [NP-1:0] m, input bit stall);
        logic [NP+1:0] e;
        @(negedge clk);
        in_port = PW'(p); in_kind = 2'(k); in_match = m; in_valid = 1'b1;
        e = model(p, k, m);
        chk({req, " R2 ready"}, int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R2 valid"}, int'(out_valid), 1);
        chk({req, " code"}, int'(out_code), int'(e[1:0]));
        chk({req, " R11 egress"}, int'(out_egress), int'(e[NP+1:2]));
        if (stall) begin
            out_ready = 1'b0;
            @(negedge clk);
            chk("R2 held valid", int'(out_valid), 1);
            chk("R2 held code", int'(out_code), int'(e[1:0]));
            chk("R2 ready low", int'(in_ready), 0);
            out_ready = 1'b1;
            @(negedge clk);
            chk("R2 drained", int'(out_valid), 0);
        end
    endtask

    task automatic set_en(input logic [NP-1:0] me, ie, be, ve, ue);
        mem_en = me; io_en = ie; bm_en = be; vga_en = ve; upfwd_en = ue;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 reset valid", int'(out_valid), 0);
        chk("R1 reset ready", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 post-reset valid", int'(out_valid), 0);

        set_en('1, '1, '1, '0, '0);
        run_one("R6 up to lowest ds", 0, 0, 5'b10101, 0);           // egress port 2
        run_one("R6 up miss", 0, 0, 5'b00001, 0);                   // code 3
        run_one("R7 ds to other ds", 3, 1, 5'b11000, 0);            // egress port 4
        run_one("R7 ds to upstream", 2, 0, 5'b00001, 0);
        run_one("R8 loopback blocked", 2, 0, 5'b00101, 1);          // code 3
        set_en('1, '1, '1, '0, 5'b00100);
        run_one("R8 loopback forwarded", 2, 0, 5'b00100, 0);        // egress port 0
        set_en('1, '1, 5'b11110, '0, '0);
        run_one("R5 upstream bme clear", 1, 0, 5'b00001, 0);        // code 2
        set_en('1, '1, 5'b11101, '0, '0);
        run_one("R4 ds bme clear", 1, 0, 5'b01000, 0);              // code 2
        set_en('1, 5'b11011, '1, '0, '0);
        run_one("R3 io disabled", 2, 1, 5'b00010, 0);               // code 1
        set_en(5'b11110, '1, '1, '0, '0);
        run_one("R3 mem disabled up", 0, 2, 5'b00010, 0);           // code 1
        set_en('1, '1, '1, 5'b01000, '0);
        run_one("R9 vga from vga port", 3, 2, 5'b00010, 0);         // code 3
        run_one("R9 vga other port", 1, 2, 5'b00100, 0);            // egress port 2
        set_en(5'b11011, '1, 5'b11011, '1, '0);
        run_one("R10 all faults", 2, 2, 5'b00000, 0);               // code 1
        set_en('1, '1, 5'b11011, '1, '0);
        run_one("R10 master over route", 2, 2, 5'b00000, 0);        // code 2
        set_en('0, '0, '0, '0, '0);
        run_one("R12 reserved kind", 0, 3, 5'b11111, 1);            // code 3

        for (int n = 0; n < 400; n++) begin
            set_en(NP'($urandom | $urandom | $urandom), NP'($urandom | $urandom),
                   NP'($urandom | $urandom | $urandom), NP'($urandom), NP'($urandom));
            run_one("R7 random", int'($urandom_range(NP-1, 0)), int'($urandom_range(3, 0)),
                    NP'($urandom), ($urandom_range(7, 0) == 0));
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule